// File: doc/BRIEF.md
# Receive Line Buffer with Status and DMA Handshake

This block holds incoming characters on the receive side of a 16550-class serial port and derives the status that bus software and a DMA engine need. A receive shift register outside the block delivers complete characters, each with a one-cycle valid strobe. In buffered mode the characters are queued in a byte FIFO. In unbuffered mode the same storage is limited to one slot, which acts as a single holding register. Software reads characters through a receive-buffer read strobe. A separate strobe reads the line status, and that read clears the sticky overrun flag.

A write-only control register sets four things: the buffered/unbuffered choice, the receive trigger level, the DMA signalling mode, and a self-clearing flush of the transmit FIFO. The transmit FIFO lives outside this block. The block sees its occupancy as an input and sends it a one-cycle flush pulse. Two DMA request outputs, one for receive and one for transmit, follow either single-transfer rules or multi-transfer rules.

Top module: `rx_line_buffer`

## Requirements
- R1: After reset the block is unbuffered and in DMA mode 0, and the receive storage is empty. `data_ready`, `overrun`, `trig_hit`, `rxrdy` and `tx_flush` are 0, and `txrdy` is 1 when `tx_used` is 0.
- R2: Control bits 0 and 1 select the trigger level. With bit0=0 and bit1=0 the level is 1. With bit0=0 and bit1=1 it is 4. With bit0=1 and bit1=0 it is 8. With bit0=1 and bit1=1 it is 14. In buffered mode (control bit 7 = 1), `trig_hit` is 1 exactly when the stored count is at least the level.
- R3: In buffered mode, up to 16 characters are kept and returned in arrival order on `rbr_data`, which shows the oldest character. `data_ready` is 1 while at least one character is stored and 0 once all have been read.
- R4: In buffered mode, overrun is raised only when 16 characters are held and one more arrives with no read in the same cycle. That character is discarded.
- R5: `overrun` goes to 1 in the cycle after the overrun event. It goes to 0 in the cycle after a `lsr_rd` strobe. If a new overrun event and `lsr_rd` happen in the same cycle, the flag stays 1.
- R6: In unbuffered mode, one character is held. A character that arrives while `data_ready` is 1 sets overrun and is discarded, and the held character is kept.
- R7: In DMA mode 0, `rxrdy` is 1 while at least one character is stored, and `txrdy` is 1 only when `tx_used` is 0.
- R8: In DMA mode 1, `rxrdy` rises when the count reaches the trigger level and stays 1 until the storage is empty. `txrdy` is 1 while `tx_used` is below 16.
- R9: Control bit 4 selects DMA mode 1 only when bit 7 is 1. When bit 7 is 0, the block follows mode 0 rules whatever bit 4 holds.
- R10: Writing control bit 5 as 1 drives `tx_flush` high for exactly the one cycle after the write. The bit is not stored.
- R11: A control write that changes bit 7 empties the receive storage.
- R12: Control bits 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| rx_valid | input | 1 | A complete character is ready in the shift register |
| rx_char | input | 8 | The character from the shift register |
| rbr_rd | input | 1 | Receive buffer read strobe; pops the oldest character |
| rbr_data | output | 8 | Oldest stored character |
| lsr_rd | input | 1 | Line status read strobe; clears overrun |
| tx_used | input | 5 | Occupancy of the external transmit FIFO |
| data_ready | output | 1 | At least one character is stored |
| overrun | output | 1 | Sticky overrun flag |
| trig_hit | output | 1 | Count has reached the trigger level |
| rxrdy | output | 1 | Receive DMA request |
| txrdy | output | 1 | Transmit DMA request |
| tx_flush | output | 1 | One-cycle transmit FIFO flush pulse |

## Verification
A control write, a character arrival and a receive read all take effect at the clock edge that samples them. `data_ready`, `trig_hit`, `rxrdy`, `txrdy` and `rbr_data` follow from state registered at that edge, so they are correct one half-cycle later. `overrun` and `tx_flush` are registers of their own, and they too show their new value right after the edge at which the event was sampled. `tx_flush` falls again one cycle later. The bench drives every strobe for exactly one cycle from a falling edge and samples at the next falling edge, so each check reads the result of exactly one edge.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   localparam int LVL_W = 5;

   // Receive trigger level decode; the ordering is deliberately nonlinear.
   function automatic logic [LVL_W-1:0] trig_level(input logic sel0, input logic sel1);
      logic [LVL_W-1:0] lvl;
      case ({sel0, sel1})
         2'b00:   lvl = 5'd1;
         2'b01:   lvl = 5'd4;
         2'b10:   lvl = 5'd8;
         default: lvl = 5'd14;
      endcase
      return lvl;
   endfunction

endpackage

// File: rtl/rxf_ctl.sv
module rxf_ctl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [7:0] wdata,
   output logic       fifo_en,
   output logic       dma_sel,
   output logic       sel0,
   output logic       sel1,
   output logic       tx_flush,
   output logic       rx_clear
);

   localparam int BIT_SEL0  = 0;
   localparam int BIT_SEL1  = 1;
   localparam int BIT_DMA   = 4;
   localparam int BIT_FLUSH = 5;
   localparam int BIT_EN    = 7;

   logic dma_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fifo_en  <= 1'b0;
         dma_bit  <= 1'b0;
         sel0     <= 1'b0;
         sel1     <= 1'b0;
         tx_flush <= 1'b0;
      end else begin
         tx_flush <= wr & wdata[BIT_FLUSH];
         if (wr) begin
            fifo_en <= wdata[BIT_EN];
            dma_bit <= wdata[BIT_DMA];
            sel0    <= wdata[BIT_SEL0];
            sel1    <= wdata[BIT_SEL1];
         end
      end
   end

   assign dma_sel  = fifo_en & dma_bit;
   assign rx_clear = wr & (wdata[BIT_EN] ^ fifo_en);

   // R10: a flush pulse is always the echo of a flush write one cycle earlier
   a_r10_flush_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      tx_flush |-> $past(wr && wdata[BIT_FLUSH]));

   // R10: the flush bit is not held; no pulse without a fresh write
   a_r10_flush_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && wdata[BIT_FLUSH]) |=> !tx_flush);

endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter  int DEPTH = 16,
   parameter  int W     = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          single,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          ovr_evt
);

   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cap;
   logic          pop_ok, push_ok, wr_en;
   logic [W-1:0]  ent [DEPTH];

   assign cap     = single ? CW'(1) : CW'(DEPTH);
   assign pop_ok  = pop & (count != '0);
   assign push_ok = push & ((count < cap) | pop_ok);
   assign wr_en   = push_ok & ~clear;
   assign ovr_evt = push & ~push_ok & ~clear;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_ent
         logic [W-1:0] q;
         always_ff @(posedge clk) begin
            if (wr_en && wr_ptr == AW'(g)) q <= din;
         end
         assign ent[g] = q;
      end
   endgenerate

   assign dout = ent[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clear) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + AW'(1);
         if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
         count <= count + CW'(push_ok) - CW'(pop_ok);
      end
   end

   // R4: occupancy never exceeds the storage depth
   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   // R6: unbuffered mode never holds more than one character
   a_r6_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
      single |-> count <= CW'(1));

   // R3: an arrival into empty storage is visible on the next cycle
   a_r3_push_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (push && count == '0 && !clear) |=> count != '0);

   // R11: a clear leaves the storage empty
   a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> count == '0);

endmodule

// File: rtl/rxf_status.sv
module rxf_status #(
   parameter  int CW      = 5,
   parameter  int TXDEPTH = 16,
   localparam int TXCW    = $clog2(TXDEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CW-1:0]   count,
   input  logic [CW-1:0]   lvl,
   input  logic            fifo_en,
   input  logic            dma_sel,
   input  logic            ovr_evt,
   input  logic            lsr_rd,
   input  logic [TXCW-1:0] tx_used,
   output logic            overrun,
   output logic            trig_hit,
   output logic            rxrdy,
   output logic            txrdy
);

   logic at_lvl, nonempty, arm;

   assign nonempty = count != '0;
   assign at_lvl   = count >= lvl;
   assign trig_hit = fifo_en ? at_lvl : nonempty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        arm <= 1'b0;
      else if (!nonempty) arm <= 1'b0;
      else if (at_lvl)    arm <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       overrun <= 1'b0;
      else if (ovr_evt) overrun <= 1'b1;
      else if (lsr_rd)  overrun <= 1'b0;
   end

   assign rxrdy = dma_sel ? ((at_lvl | arm) & nonempty) : nonempty;
   assign txrdy = dma_sel ? (tx_used < TXCW'(TXDEPTH)) : (tx_used == '0);

   // R5: a status read without a new event clears the flag
   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !ovr_evt) |=> !overrun);

   // R5: an overrun event always sets the flag, even against a status read
   a_r5_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_evt |=> overrun);

   // R8: no receive request while storage is empty
   a_r8_idle_no_request: assert property (@(posedge clk) disable iff (!rst_n)
      !nonempty |-> !rxrdy);

   // R8: in mode 1 a raised request holds while data remains and mode is unchanged
   a_r8_request_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (rxrdy && dma_sel) |=> (!nonempty || !dma_sel || rxrdy));

endmodule

// File: rtl/rx_line_buffer.sv
module rx_line_buffer #(
   parameter  int DEPTH   = 16,
   parameter  int TXDEPTH = 16,
   localparam int CW      = $clog2(DEPTH + 1),
   localparam int TXCW    = $clog2(TXDEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctl_wr,
   input  logic [7:0]      ctl_wdata,
   input  logic            rx_valid,
   input  logic [7:0]      rx_char,
   input  logic            rbr_rd,
   output logic [7:0]      rbr_data,
   input  logic            lsr_rd,
   input  logic [TXCW-1:0] tx_used,
   output logic            data_ready,
   output logic            overrun,
   output logic            trig_hit,
   output logic            rxrdy,
   output logic            txrdy,
   output logic            tx_flush
);
   import rxf_pkg::*;

   generate
      if (DEPTH < 16 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rx_line_buffer: DEPTH must be a power of two of at least 16");
      end
      if (TXDEPTH < 1) begin : g_bad_txdepth
         $error("rx_line_buffer: TXDEPTH must be positive");
      end
   endgenerate

   logic          fifo_en, dma_sel, sel0, sel1, rx_clear, ovr_evt;
   logic [CW-1:0] count, lvl;

   rxf_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (ctl_wr),
      .wdata    (ctl_wdata),
      .fifo_en  (fifo_en),
      .dma_sel  (dma_sel),
      .sel0     (sel0),
      .sel1     (sel1),
      .tx_flush (tx_flush),
      .rx_clear (rx_clear)
   );

   assign lvl = CW'(trig_level(sel0, sel1));

   rxf_store #(.DEPTH(DEPTH), .W(8)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (rx_clear),
      .single  (~fifo_en),
      .push    (rx_valid),
      .din     (rx_char),
      .pop     (rbr_rd),
      .dout    (rbr_data),
      .count   (count),
      .ovr_evt (ovr_evt)
   );

   rxf_status #(.CW(CW), .TXDEPTH(TXDEPTH)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .count    (count),
      .lvl      (lvl),
      .fifo_en  (fifo_en),
      .dma_sel  (dma_sel),
      .ovr_evt  (ovr_evt),
      .lsr_rd   (lsr_rd),
      .tx_used  (tx_used),
      .overrun  (overrun),
      .trig_hit (trig_hit),
      .rxrdy    (rxrdy),
      .txrdy    (txrdy)
   );

   assign data_ready = count != '0;

   // R9: mode 1 signalling is never active while unbuffered
   a_r9_mode_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && tx_used != '0) |-> !txrdy);

endmodule

// File: tb/rx_line_buffer_test.sv
module rx_line_buffer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = 8'h00;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_char = 8'h00;
   logic       rbr_rd = 1'b0;
   logic [7:0] rbr_data;
   logic       lsr_rd = 1'b0;
   logic [4:0] tx_used = 5'd0;
   logic       data_ready, overrun, trig_hit, rxrdy, txrdy, tx_flush;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   rx_line_buffer uut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .rx_valid(rx_valid), .rx_char(rx_char), .rbr_rd(rbr_rd), .rbr_data(rbr_data),
      .lsr_rd(lsr_rd), .tx_used(tx_used), .data_ready(data_ready), .overrun(overrun),
      .trig_hit(trig_hit), .rxrdy(rxrdy), .txrdy(txrdy), .tx_flush(tx_flush)
   );

   task automatic chk(input string tag, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
      end
   endtask

   // All drivers start at a falling edge and return at the next one.
   task automatic ctl_write(input logic [7:0] v);
      ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic push(input logic [7:0] v);
      rx_valid = 1'b1; rx_char = v;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic pop();
      rbr_rd = 1'b1;
      @(negedge clk);
      rbr_rd = 1'b0;
   endtask

   task automatic status_read();
      lsr_rd = 1'b1;
      @(negedge clk);
      lsr_rd = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 data_ready", data_ready, 0);
      chk("R1 overrun", overrun, 0);
      chk("R1 trig_hit", trig_hit, 0);
      chk("R1 rxrdy", rxrdy, 0);
      chk("R1 tx_flush", tx_flush, 0);
      chk("R1 txrdy", txrdy, 1);
   endtask

   task automatic t_holding();
      push(8'h41);
      chk("R6 ready", data_ready, 1);
      chk("R6 data", rbr_data, 8'h41);
      push(8'h42);
      chk("R6 overrun", overrun, 1);
      chk("R6 kept", rbr_data, 8'h41);
      status_read();
      chk("R5 cleared", overrun, 0);
      rx_valid = 1'b1; rx_char = 8'h43; lsr_rd = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; lsr_rd = 1'b0;
      chk("R5 set wins", overrun, 1);
      pop();
      chk("R6 drained", data_ready, 0);
      status_read();
      chk("R5 cleared again", overrun, 0);
   endtask

   task automatic t_order();
      ctl_write(8'h80);
      for (int i = 0; i < 5; i++) push(8'(8'h10 + i * 7));
      chk("R3 ready", data_ready, 1);
      for (int i = 0; i < 5; i++) begin
         chk("R3 order", rbr_data, 8'h10 + i * 7);
         pop();
      end
      chk("R3 empty", data_ready, 0);
   endtask

   task automatic t_trigger();
      int lv [4] = '{1, 4, 8, 14};
      for (int c = 0; c < 4; c++) begin
         ctl_write(8'h00);
         ctl_write(8'(8'h80 | (c[1] ? 1 : 0) | (c[0] ? 2 : 0)));
         for (int k = 0; k < lv[c] - 1; k++) push(8'(k));
         chk("R2 below level", trig_hit, 0);
         push(8'hFF);
         chk("R2 at level", trig_hit, 1);
      end
      ctl_write(8'h00);
      chk("R11 cleared by disable", data_ready, 0);
   endtask

   task automatic t_overrun();
      ctl_write(8'h80);
      for (int i = 0; i < 16; i++) push(8'(i * 3 + 1));
      chk("R4 no overrun at full", overrun, 0);
      push(8'hEE);
      chk("R4 overrun", overrun, 1);
      for (int i = 0; i < 16; i++) begin
         chk("R4 kept data", rbr_data, i * 3 + 1);
         pop();
      end
      chk("R4 extra dropped", data_ready, 0);
      status_read();
      chk("R5 cleared", overrun, 0);
   endtask

   task automatic t_dma0();
      chk("R7 rxrdy empty", rxrdy, 0);
      push(8'h55);
      chk("R7 rxrdy one", rxrdy, 1);
      tx_used = 5'd0;
      #1 chk("R7 txrdy empty", txrdy, 1);
      tx_used = 5'd3;
      #1 chk("R7 txrdy busy", txrdy, 0);
      pop();
      tx_used = 5'd0;
   endtask

   task automatic t_dma1();
      ctl_write(8'h00);
      ctl_write(8'h92);
      for (int i = 0; i < 3; i++) push(8'(i));
      chk("R8 below level", rxrdy, 0);
      push(8'h03);
      chk("R8 at level", rxrdy, 1);
      pop(); pop();
      chk("R8 held", rxrdy, 1);
      pop(); pop();
      chk("R8 empty", rxrdy, 0);
      tx_used = 5'd3;
      #1 chk("R8 txrdy room", txrdy, 1);
      tx_used = 5'd16;
      #1 chk("R8 txrdy full", txrdy, 0);
      tx_used = 5'd0;
   endtask

   task automatic t_gate();
      ctl_write(8'h10);
      tx_used = 5'd3;
      #1 chk("R9 mode0 rules", txrdy, 0);
      tx_used = 5'd0;
   endtask

   task automatic t_flush_reserved();
      ctl_write(8'hA0);
      chk("R10 pulse", tx_flush, 1);
      @(negedge clk);
      chk("R10 self clear", tx_flush, 0);
      ctl_write(8'h8D);
      for (int i = 0; i < 7; i++) push(8'(i));
      chk("R12 reserved ignored below", trig_hit, 0);
      push(8'h07);
      chk("R12 reserved ignored at 8", trig_hit, 1);
      ctl_write(8'h81);
      chk("R11 no clear without change", data_ready, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_holding();
      t_order();
      t_trigger();
      t_overrun();
      t_dma0();
      t_dma1();
      t_gate();
      t_flush_reserved();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule